// File: doc/BRIEF.md
# Strided Page Mover

This block copies whole pages between the local scratchpad and off-chip memory on one command. A command names a starting off-chip byte address, a starting scratchpad word address, a block length in bus beats, a stride in bytes and a block count. A page-load gathers each strided block from off-chip memory and packs the blocks back to back in the scratchpad. A page-store reads the same packed region out of the scratchpad and scatters it to the strided off-chip locations. The bytes that lie between blocks never cross the bus.

The off-chip bus takes one burst request at a time. Its latency is fixed and set by a parameter, 40 cycles by default. After that delay, one data beat of DW bits moves per cycle, with no gaps; at the default width a beat is 4 bytes. Each block costs exactly one request, so the latency is paid once per block and not once per line. Software starts a transfer with a valid/ready handshake and learns that it has finished from a one-cycle done pulse and from a sticky completion flag.

Top module: `strided_page_mover`

## Requirements
- R1: On a page-load beat (`cmd_store`=0 at acceptance), `sp_we` is 1 and `sp_wdata` equals `mem_rdata` in that same cycle. `sp_we` is 0 in every cycle that is not a load beat.
- R2: `cmd_ready` is 1 exactly when the engine is idle. A command offered while the engine is busy is ignored and leaves the running transfer unchanged.
- R3: Each block issues exactly one `mem_req` cycle. For block k (counted from 0), `mem_req_addr` is base + k*stride modulo 2^AW, `mem_req_len` is the block length in beats, and `mem_req_we` is the command's store flag.
- R4: The first beat of a block comes exactly LAT cycles after its request cycle. Its beats then run on consecutive cycles. The next block's request falls in the cycle right after the last beat of the previous block.
- R5: On a page-store beat, `sp_we` is 0 and `mem_wdata` equals `sp_rdata` in that same cycle.
- R6: During beat i of block k, `sp_addr` is sp_base + k*len + i modulo 2^SPW, where the scratchpad address counts DW-bit words.
- R7: `done` is high for one cycle, in the cycle after the last beat of the last block. `done_sticky` rises in that same cycle, stays high, and clears only in the cycle after the next command is accepted.
- R8: A command with block count 0 or block length 0 makes no request and no beat. It raises `done` and `done_sticky` in the cycle after acceptance.
- R9: `busy` is 0 out of reset. It is 1 from the cycle after a non-empty command is accepted through its last beat, and 0 in the `done` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle, command will be taken |
| cmd_store | input | 1 | 1 = page-store, 0 = page-load |
| cmd_ext_base | input | AW | Off-chip byte address of the first block |
| cmd_sp_base | input | SPW | Scratchpad word address of the first beat |
| cmd_blk_len | input | LW | Beats per block |
| cmd_stride | input | AW | Byte distance between block starts |
| cmd_blk_cnt | input | CW | Number of blocks |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| done_sticky | output | 1 | Completion flag held until next command |
| mem_req | output | 1 | Burst request strobe |
| mem_req_we | output | 1 | Request is a write to memory |
| mem_req_addr | output | AW | Burst start byte address |
| mem_req_len | output | LW | Burst length in beats |
| mem_beat | output | 1 | Data beat moves on the bus this cycle |
| mem_rdata | input | DW | Read beat data from memory |
| mem_wdata | output | DW | Write beat data to memory |
| sp_we | output | 1 | Scratchpad write enable |
| sp_addr | output | SPW | Scratchpad word address |
| sp_wdata | output | DW | Scratchpad write data |
| sp_rdata | input | DW | Scratchpad read data (combinational) |

## Verification
The bench aims at the cycle where one block hands over to the next. A design that is off by one in its latency or beat counters would move a beat a cycle early or late, or would leave a gap between the last beat and the next request. Packing across blocks and scratchpad wrap-around are both exercised. An engine that re-applied the stride to the scratchpad pointer, or that lost the carry at the top of the address range, would write to the wrong words. Commands with a zero count, commands with a zero length, back-to-back acceptance in the `done` cycle, and commands offered during a busy transfer are all included. These expose an engine that issues a stray burst, loses the sticky flag, or lets a refused command corrupt the running transfer.

// File: rtl/spm_pkg.sv
package spm_pkg;
   typedef enum logic [1:0] {
      S_IDLE = 2'd0,
      S_REQ  = 2'd1,
      S_WAIT = 2'd2,
      S_BEAT = 2'd3
   } xfer_state_e;
endpackage

// File: rtl/spm_seq.sv
module spm_seq
   import spm_pkg::*;
#(
   parameter int LAT = 40,
   parameter int LW  = 8,
   parameter int CW  = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          zero_cmd,
   input  logic [LW-1:0] blk_len,
   input  logic [CW-1:0] blk_cnt,
   output xfer_state_e   state,
   output logic [LW-1:0] len_q,
   output logic          blk_end,
   output logic          done_set,
   output logic          done
);
   localparam int LCW = (LAT > 2) ? $clog2(LAT) : 1;

   logic [LCW-1:0] lat_cnt;
   logic [LW-1:0]  beat_cnt;
   logic [CW-1:0]  blk_left;

   assign blk_end  = (state == S_BEAT) && (beat_cnt == '0);
   assign done_set = ((state == S_IDLE) && start && zero_cmd) ||
                     (blk_end && (blk_left == CW'(1)));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= S_IDLE;
         lat_cnt  <= '0;
         beat_cnt <= '0;
         blk_left <= '0;
         len_q    <= '0;
         done     <= 1'b0;
      end else begin
         done <= done_set;
         case (state)
            S_IDLE: begin
               if (start && !zero_cmd) begin
                  state    <= S_REQ;
                  len_q    <= blk_len;
                  blk_left <= blk_cnt;
               end
            end
            S_REQ: begin
               state    <= S_WAIT;
               lat_cnt  <= LCW'(LAT - 2);
               beat_cnt <= len_q - 1'b1;
            end
            S_WAIT: begin
               if (lat_cnt == '0) state <= S_BEAT;
               else               lat_cnt <= lat_cnt - 1'b1;
            end
            S_BEAT: begin
               if (beat_cnt == '0) begin
                  if (blk_left == CW'(1)) begin
                     state <= S_IDLE;
                  end else begin
                     blk_left <= blk_left - 1'b1;
                     state    <= S_REQ;
                  end
               end else begin
                  beat_cnt <= beat_cnt - 1'b1;
               end
            end
            default: state <= S_IDLE;
         endcase
      end
   end

   // R4: a request is always followed by the latency wait, never by data
   p_req_to_wait_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_REQ) |=> (state == S_WAIT));
endmodule

// File: rtl/spm_agen.sv
module spm_agen #(
   parameter int AW  = 32,
   parameter int SPW = 10
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  logic [AW-1:0]  ext_base,
   input  logic [SPW-1:0] sp_base,
   input  logic [AW-1:0]  stride,
   input  logic           beat,
   input  logic           blk_end,
   output logic [AW-1:0]  blk_addr,
   output logic [SPW-1:0] sp_ptr
);
   logic [AW-1:0] stride_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         blk_addr <= '0;
         sp_ptr   <= '0;
         stride_q <= '0;
      end else if (start) begin
         blk_addr <= ext_base;
         sp_ptr   <= sp_base;
         stride_q <= stride;
      end else begin
         if (beat)    sp_ptr   <= sp_ptr + 1'b1;
         if (blk_end) blk_addr <= blk_addr + stride_q;
      end
   end

   // R6: consecutive beats land on consecutive scratchpad words
   p_sp_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (beat && $past(beat) && !$past(start)) |-> (sp_ptr == SPW'($past(sp_ptr) + 1'b1)));
endmodule

// File: rtl/strided_page_mover.sv
module strided_page_mover
   import spm_pkg::*;
#(
   parameter int AW  = 32,
   parameter int SPW = 10,
   parameter int LW  = 8,
   parameter int CW  = 8,
   parameter int DW  = 32,
   parameter int LAT = 40
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           cmd_valid,
   output logic           cmd_ready,
   input  logic           cmd_store,
   input  logic [AW-1:0]  cmd_ext_base,
   input  logic [SPW-1:0] cmd_sp_base,
   input  logic [LW-1:0]  cmd_blk_len,
   input  logic [AW-1:0]  cmd_stride,
   input  logic [CW-1:0]  cmd_blk_cnt,
   output logic           busy,
   output logic           done,
   output logic           done_sticky,
   output logic           mem_req,
   output logic           mem_req_we,
   output logic [AW-1:0]  mem_req_addr,
   output logic [LW-1:0]  mem_req_len,
   output logic           mem_beat,
   input  logic [DW-1:0]  mem_rdata,
   output logic [DW-1:0]  mem_wdata,
   output logic           sp_we,
   output logic [SPW-1:0] sp_addr,
   output logic [DW-1:0]  sp_wdata,
   input  logic [DW-1:0]  sp_rdata
);
   localparam int BEAT_BYTES = DW / 8;

   initial begin
      assert (LAT >= 2) else $error("LAT must be at least 2");
      assert (BEAT_BYTES > 0 && (DW % 8) == 0) else $error("DW must be whole bytes");
      assert (LW >= 1 && CW >= 1 && SPW >= 1) else $error("widths must be positive");
   end

   xfer_state_e state;
   logic        accept, zero_cmd, blk_end, done_set, store_q;

   assign accept   = cmd_valid && cmd_ready;
   assign zero_cmd = (cmd_blk_len == '0) || (cmd_blk_cnt == '0);

   spm_seq #(.LAT(LAT), .LW(LW), .CW(CW)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (accept),
      .zero_cmd (zero_cmd),
      .blk_len  (cmd_blk_len),
      .blk_cnt  (cmd_blk_cnt),
      .state    (state),
      .len_q    (mem_req_len),
      .blk_end  (blk_end),
      .done_set (done_set),
      .done     (done)
   );

   spm_agen #(.AW(AW), .SPW(SPW)) u_agen (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (accept),
      .ext_base (cmd_ext_base),
      .sp_base  (cmd_sp_base),
      .stride   (cmd_stride),
      .beat     (mem_beat),
      .blk_end  (blk_end),
      .blk_addr (mem_req_addr),
      .sp_ptr   (sp_addr)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         store_q     <= 1'b0;
         done_sticky <= 1'b0;
      end else begin
         if (accept)        store_q     <= cmd_store;
         if (done_set)      done_sticky <= 1'b1;
         else if (accept)   done_sticky <= 1'b0;
      end
   end

   assign busy       = (state != S_IDLE);
   assign cmd_ready  = !busy;
   assign mem_req    = (state == S_REQ);
   assign mem_req_we = store_q;
   assign mem_beat   = (state == S_BEAT);
   assign sp_we      = mem_beat && !store_q;
   assign sp_wdata   = mem_rdata;
   assign mem_wdata  = (mem_beat && store_q) ? sp_rdata : '0;

   // R2: no command is taken while data is moving
   p_beat_not_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
      mem_beat |-> !cmd_ready);
   // R9: acceptance leads straight to a request or to completion
   p_accept_next_r9: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> (mem_req || done));
   // R4: the cycle after a request carries neither data nor another request
   p_req_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |=> (!mem_beat && !mem_req));
   // R7: the pulse is always accompanied by the flag
   p_done_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> done_sticky);
   // R7: the flag holds until a command is accepted
   p_sticky_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (done_sticky && !accept) |=> done_sticky);
   // R8: an empty command never makes the engine busy
   p_zero_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && zero_cmd) |=> !busy);
endmodule

// File: tb/strided_page_mover_tb.sv
module strided_page_mover_tb;
   localparam int AW = 32, SPW = 10, LW = 8, CW = 8, DW = 32, LAT = 40;

   logic clk = 1'b0;
   always #10ns clk = ~clk;

   logic           rst_n, cmd_valid, cmd_ready, cmd_store;
   logic [AW-1:0]  cmd_ext_base, cmd_stride;
   logic [SPW-1:0] cmd_sp_base;
   logic [LW-1:0]  cmd_blk_len;
   logic [CW-1:0]  cmd_blk_cnt;
   logic           busy, done, done_sticky, mem_req, mem_req_we, mem_beat, sp_we;
   logic [AW-1:0]  mem_req_addr;
   logic [LW-1:0]  mem_req_len;
   logic [DW-1:0]  mem_rdata, mem_wdata, sp_wdata, sp_rdata;
   logic [SPW-1:0] sp_addr;

   strided_page_mover #(.AW(AW), .SPW(SPW), .LW(LW), .CW(CW), .DW(DW), .LAT(LAT)) u_dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_store(cmd_store), .cmd_ext_base(cmd_ext_base), .cmd_sp_base(cmd_sp_base),
      .cmd_blk_len(cmd_blk_len), .cmd_stride(cmd_stride), .cmd_blk_cnt(cmd_blk_cnt),
      .busy(busy), .done(done), .done_sticky(done_sticky), .mem_req(mem_req),
      .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr), .mem_req_len(mem_req_len),
      .mem_beat(mem_beat), .mem_rdata(mem_rdata), .mem_wdata(mem_wdata),
      .sp_we(sp_we), .sp_addr(sp_addr), .sp_wdata(sp_wdata), .sp_rdata(sp_rdata)
   );

   typedef struct {
      bit             busy, req, we, beat, done, sticky;
      logic [AW-1:0]  raddr, eaddr;
      logic [LW-1:0]  rlen;
      logic [SPW-1:0] saddr;
   } ent_t;

   ent_t q[$];
   int   n_cmp = 0, n_bad = 0;
   bit   m_sticky = 1'b0;
   bit   arm = 1'b0;

   function automatic logic [DW-1:0] pat_ext(logic [AW-1:0] a);
      return a ^ 32'hA5C3_0000;
   endfunction

   function automatic logic [DW-1:0] pat_sp(logic [SPW-1:0] a);
      return 32'(a) * 32'h9E37_79B1 + 32'h1234;
   endfunction

   function automatic ent_t idle_ent();
      ent_t e;
      e.busy = 0; e.req = 0; e.we = 0; e.beat = 0; e.done = 0; e.sticky = 0;
      e.raddr = '0; e.eaddr = '0; e.rlen = '0; e.saddr = '0;
      return e;
   endfunction

   function automatic void push_cmd(bit st, logic [AW-1:0] base, logic [SPW-1:0] sp,
                                    int len, logic [AW-1:0] stride, int cnt);
      ent_t e;
      if (len == 0 || cnt == 0) begin
         e = idle_ent(); e.done = 1; e.sticky = 1; q.push_back(e);
         return;
      end
      for (int b = 0; b < cnt; b++) begin
         e = idle_ent(); e.busy = 1; e.req = 1; e.we = st;
         e.raddr = base + stride * AW'(b); e.rlen = LW'(len);
         q.push_back(e);
         for (int w = 0; w < LAT - 1; w++) begin
            e = idle_ent(); e.busy = 1; q.push_back(e);
         end
         for (int i = 0; i < len; i++) begin
            e = idle_ent(); e.busy = 1; e.beat = 1; e.we = st;
            e.eaddr = base + stride * AW'(b) + AW'(4 * i);
            e.saddr = SPW'(int'(sp) + b * len + i);
            q.push_back(e);
         end
      end
      e = idle_ent(); e.done = 1; e.sticky = 1; q.push_back(e);
   endfunction

   task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic step();
      ent_t e;
      @(negedge clk);
      cmd_valid = arm;
      if (q.size() > 0) e = q.pop_front();
      else begin e = idle_ent(); e.sticky = m_sticky; end
      m_sticky = e.sticky;
      mem_rdata = (e.beat && !e.we) ? pat_ext(e.eaddr) : 32'hDEAD_BEEF;
      sp_rdata  = (e.beat && e.we)  ? pat_sp(e.saddr)  : 32'h0BAD_F00D;
      #1ns;
      chk("R9", "busy", 64'(busy), 64'(e.busy));
      chk("R2", "cmd_ready", 64'(cmd_ready), 64'(!e.busy));
      chk("R3", "mem_req", 64'(mem_req), 64'(e.req));
      if (e.req) begin
         chk("R3", "mem_req_addr", 64'(mem_req_addr), 64'(e.raddr));
         chk("R3", "mem_req_len", 64'(mem_req_len), 64'(e.rlen));
         chk("R3", "mem_req_we", 64'(mem_req_we), 64'(e.we));
      end
      chk("R4", "mem_beat", 64'(mem_beat), 64'(e.beat));
      if (e.beat) begin
         chk("R6", "sp_addr", 64'(sp_addr), 64'(e.saddr));
         if (e.we) begin
            chk("R5", "sp_we on store", 64'(sp_we), 64'(0));
            chk("R5", "mem_wdata", 64'(mem_wdata), 64'(pat_sp(e.saddr)));
         end else begin
            chk("R1", "sp_we on load", 64'(sp_we), 64'(1));
            chk("R1", "sp_wdata", 64'(sp_wdata), 64'(pat_ext(e.eaddr)));
         end
      end else begin
         chk("R1", "sp_we outside beat", 64'(sp_we), 64'(0));
      end
      chk("R7", "done", 64'(done), 64'(e.done));
      chk("R7", "done_sticky", 64'(done_sticky), 64'(e.sticky));
   endtask

   task automatic issue(bit st, logic [AW-1:0] base, logic [SPW-1:0] sp, int len,
                        logic [AW-1:0] stride, int cnt, bit b2b);
      while (q.size() > (b2b ? 1 : 0)) step();
      cmd_store = st; cmd_ext_base = base; cmd_sp_base = sp;
      cmd_blk_len = LW'(len); cmd_stride = stride; cmd_blk_cnt = CW'(cnt);
      arm = 1'b1;
      step();
      arm = 1'b0;
      push_cmd(st, base, sp, len, stride, cnt);
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      #3ms;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished at %0t", $time);
      summary();
      $finish;
   end

   initial begin
      rst_n = 1'b0; cmd_valid = 1'b0; cmd_store = 1'b0;
      cmd_ext_base = '0; cmd_sp_base = '0; cmd_blk_len = '0; cmd_stride = '0; cmd_blk_cnt = '0;
      mem_rdata = '0; sp_rdata = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // reset state: idle, ready, no flags (R9, R2, R7)
      repeat (3) step();
      // R1 R3 R4 R6: strided page-load, three blocks
      issue(1'b0, 32'h0000_1000, 10'h010, 4, 32'd64, 3, 1'b0);
      // R5: page-store accepted in the done cycle of the previous command
      issue(1'b1, 32'h0000_2000, 10'h020, 2, 32'h100, 2, 1'b1);
      // R8: zero block count, then zero block length back to back
      issue(1'b0, 32'h0000_9000, 10'h000, 5, 32'd16, 0, 1'b0);
      issue(1'b1, 32'h0000_9100, 10'h000, 0, 32'd16, 3, 1'b1);
      // single one-beat block
      issue(1'b0, 32'h0000_3000, 10'h005, 1, 32'd0, 1, 1'b0);
      // R6: scratchpad pointer wraps across the top of its range
      issue(1'b0, 32'h0000_4000, 10'h3FE, 3, 32'd12, 2, 1'b0);
      // R2: commands offered during a busy store are ignored
      issue(1'b1, 32'h0000_5000, 10'h040, 3, 32'h40, 2, 1'b0);
      repeat (5) step();
      cmd_store = 1'b0; cmd_ext_base = 32'hFFFF_0000; cmd_sp_base = 10'h3AA;
      cmd_blk_len = 8'd9; cmd_stride = 32'd4; cmd_blk_cnt = 8'd7;
      arm = 1'b1;
      repeat (10) step();
      arm = 1'b0;
      while (q.size() > 0) step();
      repeat (3) step();
      summary();
      $finish;
   end
endmodule